// File: doc/BRIEF.md
# Buffered Serial Transmitter

This block is the sending half of a classic asynchronous serial port. A host writes bytes into it one at a time. In buffered mode the bytes queue in a 32-entry first-in first-out store. In single mode a lone holding register takes each byte instead. A shifter then sends each byte on `txd` as a start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit and one or two stop bits. Each bit lasts 16 pulses of a baud enable that comes from an external divider.

Two status bits report progress. `hold_empty` says that no byte is waiting for the shifter. `shift_empty` says that the line has gone fully quiet. A transmit interrupt tells the host when to refill. In buffered mode it fires when the fill level drops below a selectable watermark and again when the queue runs dry. In single mode it fires each time the holding register empties. An optional clear-to-send gate lets the far end pause transmission between characters.

Top module: `uart_tx_fifo`

## Requirements
- R1: Each frame on `txd` is one low start bit, then the data bits least significant bit first, with the count set by `word_len` (00=5, 01=6, 10=7, 11=8 bits).
- R2: When `parity_en`=1, a parity bit follows the data. It makes the count of ones even when `parity_even`=1 and odd when `parity_even`=0. Then come one high stop bit, or two when `stop_two`=1.
- R3: Every bit lasts exactly 16 `baud_tick` pulses. `txd` changes only on a clock edge where `baud_tick` is high, and it stays high whenever nothing is being sent.
- R4: With `fifo_mode`=1, up to 32 bytes are queued and sent in write order. A write while 32 bytes are queued is dropped.
- R5: With `fifo_mode`=0, a single holding register is used, and a write while it is occupied is dropped. `hold_empty` returns to 1 when the held byte moves into the shifter.
- R6: With `fifo_mode`=1, `hold_empty` is 1 exactly when the queue holds no byte.
- R7: `shift_empty` is 1 only when the shifter is idle and no byte is waiting. It stays 0 while the last byte is on the line, even though `hold_empty` is already 1.
- R8: With `fifo_mode`=1, the interrupt becomes pending one clock after the fill level drops from at or above the watermark to below it. `trig_sel` picks the watermark: 00=8, 01=16, 10=24, 11=30. Filling up from empty sets no pending interrupt.
- R9: The interrupt becomes pending one clock after the stored byte count falls to zero, in either mode.
- R10: `tx_int` is the pending flag gated by `tx_int_en`. A host write or an `isr_rd` pulse clears the pending flag.
- R11: When `cts_flow_en`=1 and `cts_n`=1, no new character starts. A character already on the line completes. Sending resumes once `cts_n` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| fifo_mode | input | 1 | 1 selects the 32-entry queue, 0 the single holding register; a change flushes stored bytes |
| word_len | input | 2 | Data bits per character, 5 plus this value |
| parity_en | input | 1 | Append a parity bit |
| parity_even | input | 1 | 1 selects even parity, 0 odd |
| stop_two | input | 1 | Two stop bits instead of one |
| trig_sel | input | 2 | Interrupt watermark select |
| tx_int_en | input | 1 | Transmit interrupt enable |
| isr_rd | input | 1 | Interrupt status read strobe, clears pending |
| cts_flow_en | input | 1 | Enable the clear-to-send gate |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial output |
| hold_empty | output | 1 | No byte waiting for the shifter |
| shift_empty | output | 1 | Shifter idle and no byte waiting |
| tx_int | output | 1 | Transmit interrupt request |

## Verification
A write shows up on `hold_empty` at the next clock edge. The byte enters the shifter at the first clock edge after that where `baud_tick` is high. `hold_empty` and `shift_empty` follow the count combinationally. A pending interrupt shows on `tx_int` one clock after the count change that causes it, and the enable gates it with no delay. The bench samples on the falling clock edge. The serial monitor finds the start bit and then counts `baud_tick` pulses to reach the middle of every bit: the 8th pulse for the start bit, then every 16th pulse. Interrupt and status checks are made one or two falling edges after the stimulus or condition that sets them, as these latencies give.

// File: rtl/uart_tx_fifo.sv
`timescale 1ns/1ps
module uart_tx_fifo #(
  parameter int DEPTH = 32,
  parameter int OSR   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       fifo_mode,
  input  logic [1:0] word_len,
  input  logic       parity_en,
  input  logic       parity_even,
  input  logic       stop_two,
  input  logic [1:0] trig_sel,
  input  logic       tx_int_en,
  input  logic       isr_rd,
  input  logic       cts_flow_en,
  input  logic       cts_n,
  output logic       txd,
  output logic       hold_empty,
  output logic       shift_empty,
  output logic       tx_int
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int TW = $clog2(OSR);
  localparam int FW = 12;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_prev, trig;
  logic [FW-1:0] sreg, frame;
  logic [3:0]    bits_left, dbits, flen;
  logic [TW-1:0] tcnt;
  logic          busy, mode_q, pend, par;
  logic [7:0]    head, mask;

  wire [CW-1:0] cap   = fifo_mode ? CW'(DEPTH) : CW'(1);
  wire          push  = wr_en && (cnt < cap);
  wire          cts_ok = !cts_flow_en || !cts_n;
  wire          pop   = baud_tick && !busy && (cnt != 0) && cts_ok;
  wire          flush = fifo_mode != mode_q;

  assign hold_empty  = (cnt == 0);
  assign shift_empty = hold_empty && !busy;
  assign txd         = busy ? sreg[0] : 1'b1;
  assign tx_int      = pend && tx_int_en;

  always_comb begin
    case (trig_sel)
      2'd0:    trig = CW'(DEPTH / 4);
      2'd1:    trig = CW'(DEPTH / 2);
      2'd2:    trig = CW'((3 * DEPTH) / 4);
      default: trig = CW'(DEPTH - 2);
    endcase
  end

  always_comb begin
    dbits = 4'd5 + {2'b00, word_len};
    head  = mem[rp];
    mask  = 8'hFF >> (4'd8 - dbits);
    par   = (^(head & mask)) ^ !parity_even;
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < int'(dbits)) frame[1 + i] = head[i];
    if (parity_en) frame[int'(dbits) + 1] = par;
    flen = 4'd2 + dbits + {3'b000, parity_en} + {3'b000, stop_two};
  end

  always_ff @(posedge clk)
    if (push) mem[wp] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; mode_q <= 1'b0;
    end else if (flush) begin
      wp <= '0; rp <= '0; cnt <= '0; mode_q <= fifo_mode;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; sreg <= '1; bits_left <= '0; tcnt <= '0;
    end else if (pop) begin
      busy <= 1'b1; sreg <= frame; bits_left <= flen; tcnt <= '0;
    end else if (busy && baud_tick) begin
      if (tcnt == TW'(OSR - 1)) begin
        tcnt      <= '0;
        sreg      <= {1'b1, sreg[FW-1:1]};
        bits_left <= bits_left - 1'b1;
        if (bits_left == 4'd1) busy <= 1'b0;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  wire evt = ((cnt_prev != 0) && (cnt == 0)) ||
             (fifo_mode && (cnt_prev >= trig) && (cnt < trig));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_prev <= '0; pend <= 1'b0;
    end else begin
      cnt_prev <= cnt;
      pend     <= evt || (pend && !(wr_en || isr_rd));
    end
  end
endmodule

// File: rtl/uart_tx_fifo_chk.sv
`timescale 1ns/1ps
module uart_tx_fifo_chk #(
  parameter int DEPTH = 32,
  parameter int CW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          baud_tick,
  input logic          fifo_mode,
  input logic          isr_rd,
  input logic          txd,
  input logic          hold_empty,
  input logic          shift_empty,
  input logic          tx_int,
  input logic [CW-1:0] cnt
);
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) shift_empty |-> txd); // R3
  AST_TICK_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) !$stable(txd) |-> $past(baud_tick)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH)); // R4
  AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !fifo_mode |-> cnt <= CW'(1)); // R5
  AST_SHIFT_IMPLIES_HOLD: assert property (@(posedge clk) disable iff (!rst_n) shift_empty |-> hold_empty); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (isr_rd && $stable(cnt)) |=> !tx_int); // R10
endmodule

bind uart_tx_fifo uart_tx_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .fifo_mode(fifo_mode),
  .isr_rd(isr_rd), .txd(txd), .hold_empty(hold_empty),
  .shift_empty(shift_empty), .tx_int(tx_int), .cnt(cnt)
);

// File: tb/uart_tx_fifo_tb.sv
`timescale 1ns/1ps
module uart_tx_fifo_tb;
  logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0;
  logic wr_en = 1'b0, fifo_mode = 1'b0, parity_en = 1'b0, parity_even = 1'b0;
  logic stop_two = 1'b0, tx_int_en = 1'b0, isr_rd = 1'b0, cts_flow_en = 1'b0, cts_n = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] word_len = 2'd3, trig_sel = 2'd0;
  logic txd, hold_empty, shift_empty, tx_int;
  logic [12:0] exp_q[$];
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) baud_tick <= rst_n ? ~baud_tick : 1'b0;

  uart_tx_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_mode(fifo_mode), .word_len(word_len), .parity_en(parity_en),
    .parity_even(parity_even), .stop_two(stop_two), .trig_sel(trig_sel),
    .tx_int_en(tx_int_en), .isr_rd(isr_rd), .cts_flow_en(cts_flow_en), .cts_n(cts_n),
    .txd(txd), .hold_empty(hold_empty), .shift_empty(shift_empty), .tx_int(tx_int)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic send(input logic [7:0] d, input bit accepted);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (accepted) exp_q.push_back({stop_two, parity_even, parity_en, word_len, d});
  endtask

  task automatic pulse_isr();
    @(negedge clk); isr_rd = 1'b1;
    @(negedge clk); isr_rd = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    while (!shift_empty) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic tick_wait(input int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      if (baud_tick) k++;
    end
  endtask

  // Scoreboard monitor: R1, R2, R3, R4 frame content and order
  initial begin
    logic [12:0] it;
    logic [7:0]  got, want, m;
    int nb;
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        if (exp_q.size() == 0) begin
          chk(0, "R4 unexpected frame", 1, 0);
          it = 13'h0300;
        end else it = exp_q.pop_front();
        tick_wait(8);
        chk(txd === 1'b0, "R3 start bit width", txd, 0);
        nb = 5 + it[9:8];
        got = '0;
        for (int i = 0; i < nb; i++) begin
          tick_wait(16);
          got[i] = txd;
        end
        m = 8'hFF >> (8 - nb);
        want = it[7:0] & m;
        chk(got === want, "R1 data bits", got, want);
        if (it[10]) begin
          tick_wait(16);
          chk(txd === ((^want) ^ !it[11]), "R2 parity", txd, (^want) ^ !it[11]);
        end
        for (int s = 0; s < (it[12] ? 2 : 1); s++) begin
          tick_wait(16);
          chk(txd === 1'b1, "R2 stop bit", txd, 1);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int s;
    repeat (3) @(negedge clk);
    chk(txd === 1'b1, "R3 reset idle", txd, 1);
    chk(hold_empty === 1'b1, "R6 reset hold_empty", hold_empty, 1);
    chk(shift_empty === 1'b1, "R7 reset shift_empty", shift_empty, 1);
    chk(tx_int === 1'b0, "R10 reset tx_int", tx_int, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5 single holding register
    send(8'hA5, 1);
    repeat (4) @(negedge clk);
    chk(hold_empty === 1'b1, "R5 hold_empty after load", hold_empty, 1);
    chk(shift_empty === 1'b0, "R7 busy shifter", shift_empty, 0);
    send(8'h3C, 1);
    chk(hold_empty === 1'b0, "R5 holding occupied", hold_empty, 0);
    send(8'hFF, 0);
    drain();

    // R1 R2 formats
    word_len = 2'd0; parity_en = 1'b1; parity_even = 1'b0; stop_two = 1'b1;
    send(8'h16, 1); drain();
    word_len = 2'd1; parity_even = 1'b1; stop_two = 1'b0;
    send(8'h2B, 1); drain();
    word_len = 2'd2; parity_en = 1'b0; stop_two = 1'b1;
    send(8'h55, 1); drain();
    word_len = 2'd3; parity_en = 1'b1; parity_even = 1'b1; stop_two = 1'b0;
    send(8'h81, 1); drain();
    parity_en = 1'b0;

    // R8 R9 R10 buffered mode, watermark 8
    fifo_mode = 1'b1; trig_sel = 2'd0;
    repeat (3) @(negedge clk);
    pulse_isr();
    tx_int_en = 1'b1;
    for (int i = 0; i < 12; i++) send(8'(8'h10 + i), 1);
    while (!tx_int) @(negedge clk);
    chk(hold_empty === 1'b0, "R8 below watermark not empty", hold_empty, 0);
    pulse_isr();
    chk(tx_int === 1'b0, "R10 isr read clears", tx_int, 0);
    while (!hold_empty) @(negedge clk);
    chk(shift_empty === 1'b0, "R7 last byte on line", shift_empty, 0);
    chk(hold_empty === 1'b1, "R6 queue empty", hold_empty, 1);
    repeat (2) @(negedge clk);
    chk(tx_int === 1'b1, "R9 empty interrupt", tx_int, 1);
    tx_int_en = 1'b0;
    @(negedge clk);
    chk(tx_int === 1'b0, "R10 enable gates", tx_int, 0);
    tx_int_en = 1'b1;
    @(negedge clk);
    chk(tx_int === 1'b1, "R10 enable restores", tx_int, 1);
    send(8'hC3, 1);
    chk(tx_int === 1'b0, "R10 write clears", tx_int, 0);
    drain();

    // R4 R11 full queue, gate, watermark 30
    pulse_isr();
    trig_sel = 2'd3; cts_flow_en = 1'b1; cts_n = 1'b1;
    for (int i = 0; i < 32; i++) send(8'(8'h40 + 3 * i), 1);
    send(8'hEE, 0);
    repeat (300) @(negedge clk);
    chk(txd === 1'b1, "R11 gated line idle", txd, 1);
    chk(hold_empty === 1'b0, "R11 bytes held", hold_empty, 0);
    chk(shift_empty === 1'b0, "R7 bytes waiting", shift_empty, 0);
    chk(tx_int === 1'b0, "R8 fill sets no interrupt", tx_int, 0);
    cts_n = 1'b0;
    while (!tx_int) @(negedge clk);
    chk(hold_empty === 1'b0, "R8 watermark 30", hold_empty, 0);
    cts_n = 1'b1;
    s = exp_q.size();
    repeat (800) @(negedge clk);
    chk(exp_q.size() == s, "R11 no new frame", exp_q.size(), s);
    chk(txd === 1'b1, "R11 current frame done", txd, 1);
    cts_n = 1'b0;
    drain();
    chk(exp_q.size() == 0, "R4 all frames sent", exp_q.size(), 0);
    chk(shift_empty === 1'b1, "R7 final idle", shift_empty, 1);
    summary();
    $finish;
  end
endmodule